// File: doc/BRIEF.md
# Indirect Redirection Register Block

This block holds the software-visible configuration of an interrupt router behind two bus offsets. Software first writes an index into a select register, then reads or writes the data window to reach the register that index names. Behind the window sit a read-only version word, a 4-bit router identifier, an alias of that identifier for arbitration, and a table of 64-bit redirection entries, one per input pin, each reached as a low and a high 32-bit half.

Window writes to the table have side effects. They are reported to the neighbouring pin logic the cycle after the write. A lower-half write drops the entry's remote-IRR status. A write that flips the mask bit emits a one-cycle event carrying the pin and its new mask state. A write that leaves a level-triggered entry whose pin is pending raises a re-service request for that pin. Interrupt detection and delivery stay outside. The delivery side reports an accepted level interrupt through a remote-IRR set input, and the pin side supplies the pending bits.

Top module: `irq_redir_regs`

## Requirements
- R1: With select 0x01 the window reads the version word: bits 23:16 hold the pin count minus one, bits 7:0 hold the VER_CODE parameter, and all other bits are zero. Window writes with this select change nothing.
- R2: With select 0x00 the window reads the 4-bit identifier in bits 27:24 and zero elsewhere. A window write stores bits 27:24 of the written data as the new identifier.
- R3: With select 0x02 the window reads the same word as with select 0x00. Window writes with this select change nothing.
- R4: A select value of 0x10 or above addresses table entry (select − 0x10) >> 1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. In an entry, bits 7:0 are the vector, bit 13 is polarity, bit 14 is remote IRR, bit 15 is trigger mode (1 = level) and bit 16 is mask (1 = masked).
- R5: A window write whose computed entry index is at or above the pin count changes no entry and raises no event or request. A window read of such an index returns zero.
- R6: A lower-half write always leaves the entry's remote-IRR bit at 0, whatever value bit 14 of the written data has. An upper-half write keeps it. A one-cycle pulse on rirr_set_valid sets the bit in the entry named by rirr_set_pin.
- R7: In the cycle after a table write that changes an entry's mask bit, mask_evt_valid is high for exactly one cycle, with mask_evt_pin set to the entry index and mask_evt_masked set to the new mask value. A write that leaves the mask unchanged raises no event.
- R8: In the cycle after a table write, svc_req_valid is high with svc_req_pin set to the entry index when the written entry is level-triggered and pin_pending for that pin is 1. Otherwise no request is raised.
- R9: Only address bits 7:0 are decoded. Offset 0x00 is the select register, which reads back its 8-bit value in bits 7:0. Offset 0x10 is the window. Reads of any other offset return zero, and writes to them change nothing.
- R10: A bus write with bus_wide low (narrower than 32 bits) changes no register and raises no event.
- R11: After reset every entry reads 0x00010000 (lower half) and 0x00000000 (upper half). The select register and the identifier read zero, and no event or request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | Access is 32 bits or wider |
| bus_addr | input | ADDR_W | Byte address; bits 7:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| pin_pending | input | NPINS | Pending bit of each pin from the pin logic |
| rirr_set_valid | input | 1 | Delivery side accepted a level interrupt |
| rirr_set_pin | input | PIN_W | Pin whose remote IRR is to be set |
| mask_evt_valid | output | 1 | Mask-change event pulse |
| mask_evt_pin | output | PIN_W | Pin whose mask changed |
| mask_evt_masked | output | 1 | New mask value |
| svc_req_valid | output | 1 | Re-service request pulse |
| svc_req_pin | output | PIN_W | Pin to re-service |

## Verification
A wrong index computation from the select value shows up as a readback at the wrong half or entry. It also shows up as an event that carries the wrong pin one cycle after the write. A remote-IRR bit that is not cleared, or a mask bit that is stored wrongly, appears on the next window read of that entry. A comparison that uses the stale entry in place of the freshly written one shows up one cycle after the write, as a missing or spurious mask event or service request.

// File: rtl/redir_regs_pkg.sv
// Shared constants and types for the indirect redirection register block.
// Assumes 32-bit bus data and 64-bit redirection entries.
package redir_regs_pkg;

    localparam int SEL_W     = 8;
    localparam int DATA_W    = 32;
    localparam int ENTRY_W   = 64;
    localparam int RAW_IDX_W = SEL_W - 1;

    // Bus offsets (low address byte)
    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;

    // Select codes
    localparam logic [SEL_W-1:0] SEL_IDENT      = 8'h00;
    localparam logic [SEL_W-1:0] SEL_VERSION    = 8'h01;
    localparam logic [SEL_W-1:0] SEL_ARBIT      = 8'h02;
    localparam logic [SEL_W-1:0] SEL_TABLE_BASE = 8'h10;

    // Entry field positions
    localparam int BIT_POL  = 13;
    localparam int BIT_RIRR = 14;
    localparam int BIT_TRIG = 15;
    localparam int BIT_MASK = 16;
    localparam int ID_LSB   = 24;
    localparam int ID_W     = 4;

    localparam logic [ENTRY_W-1:0] ENTRY_RESET = ENTRY_W'(1) << BIT_MASK;

    typedef enum logic [2:0] {
        RK_IDENT,
        RK_VERSION,
        RK_ARBIT,
        RK_TABLE,
        RK_NONE
    } reg_kind_e;

endpackage

// File: rtl/redir_sel_decode.sv
// Decodes the select register into a register kind, a table index and a half.
// Assumes the pin count fits in the index range reachable by an 8-bit select.
module redir_sel_decode
    import redir_regs_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [SEL_W-1:0] sel,
    output reg_kind_e        kind,
    output logic [PIN_W-1:0] idx,
    output logic             upper,
    output logic             idx_ok
);

    localparam logic [RAW_IDX_W:0] NPINS_V = (RAW_IDX_W + 1)'(NPINS);

    logic [RAW_IDX_W-1:0] raw_idx;

    // Classify the select value and derive the entry index.
    always_comb begin
        raw_idx = sel[SEL_W-1:1] - SEL_TABLE_BASE[SEL_W-1:1];
        unique case (sel)
            SEL_IDENT:   kind = RK_IDENT;
            SEL_VERSION: kind = RK_VERSION;
            SEL_ARBIT:   kind = RK_ARBIT;
            default:     kind = (sel >= SEL_TABLE_BASE) ? RK_TABLE : RK_NONE;
        endcase
        idx_ok = (kind == RK_TABLE) && ({1'b0, raw_idx} < NPINS_V);
        idx    = raw_idx[PIN_W-1:0];
        upper  = sel[0];
    end

endmodule

// File: rtl/redir_table.sv
// Storage for the redirection entries, one 64-bit word per pin.
// Applies half writes, the remote-IRR clear on lower writes and remote-IRR sets.
// Assumes wr_en is only raised for an in-range index.
module redir_table
    import redir_regs_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_upper,
    input  logic [PIN_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               set_valid,
    input  logic [PIN_W-1:0]   set_pin,
    input  logic [PIN_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic [ENTRY_W-1:0] wr_old,
    output logic [ENTRY_W-1:0] wr_new
);

    localparam logic [PIN_W:0]      NPINS_V   = (PIN_W + 1)'(NPINS);
    localparam logic [DATA_W-1:0]   RIRR_KEEP = ~(DATA_W'(1) << BIT_RIRR);

    logic [ENTRY_W-1:0] tbl [NPINS];

    // Look up the entry being written and build its next value.
    always_comb begin
        wr_old = ({1'b0, wr_idx} < NPINS_V) ? tbl[wr_idx] : '0;
        if (wr_upper) begin
            wr_new = {wr_data, wr_old[DATA_W-1:0]};
        end else begin
            wr_new = {wr_old[ENTRY_W-1:DATA_W], wr_data & RIRR_KEEP};
        end
    end

    // Read port for the window.
    always_comb begin
        rd_entry = ({1'b0, rd_idx} < NPINS_V) ? tbl[rd_idx] : '0;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_entry
        // Update one entry: reset, bus write, or remote-IRR set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[i] <= ENTRY_RESET;
            end else if (wr_en && (wr_idx == PIN_W'(i))) begin
                tbl[i] <= wr_new;
            end else if (set_valid && (set_pin == PIN_W'(i))) begin
                tbl[i][BIT_RIRR] <= 1'b1;
            end
        end

        AST_RIRR_CLEARED_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en && !wr_upper && (wr_idx == PIN_W'(i))) |-> !tbl[i][BIT_RIRR]); // R6
    end

endmodule

// File: rtl/redir_events.sv
// Registers the side-effect outputs of a table write: the mask-change event
// and the re-service request. Both appear the cycle after the write.
// Assumes wr_old and wr_new describe the entry at wr_idx in the write cycle.
module redir_events
    import redir_regs_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PIN_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_old,
    input  logic [ENTRY_W-1:0] wr_new,
    input  logic [NPINS-1:0]   pending,
    output logic               mask_evt_valid,
    output logic [PIN_W-1:0]   mask_evt_pin,
    output logic               mask_evt_masked,
    output logic               svc_req_valid,
    output logic [PIN_W-1:0]   svc_req_pin
);

    localparam logic [PIN_W:0] NPINS_V = (PIN_W + 1)'(NPINS);

    logic mask_flip;
    logic need_svc;
    logic pend_bit;

    // Decide which side effects this write causes.
    always_comb begin
        pend_bit  = ({1'b0, wr_idx} < NPINS_V) ? pending[wr_idx] : 1'b0;
        mask_flip = wr_en && (wr_old[BIT_MASK] != wr_new[BIT_MASK]);
        need_svc  = wr_en && wr_new[BIT_TRIG] && pend_bit;
    end

    // Mask-change event register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_evt_valid  <= 1'b0;
            mask_evt_pin    <= '0;
            mask_evt_masked <= 1'b0;
        end else begin
            mask_evt_valid  <= mask_flip;
            mask_evt_pin    <= wr_idx;
            mask_evt_masked <= wr_new[BIT_MASK];
        end
    end

    // Re-service request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_req_valid <= 1'b0;
            svc_req_pin   <= '0;
        end else begin
            svc_req_valid <= need_svc;
            svc_req_pin   <= wr_idx;
        end
    end

    AST_MASK_EVT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt_valid |-> $past(wr_en)); // R7
    AST_SVC_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_valid |-> $past(wr_en)); // R8

endmodule

// File: rtl/irq_redir_regs.sv
// Indirect select/window register block for an interrupt router.
// Holds the select and identifier registers, decodes bus accesses and drives
// the table and the side-effect logic. Reads are combinational in the access
// cycle, and write side effects appear one cycle after the write.
// Assumes ADDR_W >= 8 and NPINS <= 120.
module irq_redir_regs
    import redir_regs_pkg::*;
#(
    parameter int          NPINS    = 24,
    parameter int          ADDR_W   = 12,
    parameter logic [7:0]  VER_CODE = 8'h11,
    localparam int         PIN_W    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_pending,
    input  logic              rirr_set_valid,
    input  logic [PIN_W-1:0]  rirr_set_pin,
    output logic              mask_evt_valid,
    output logic [PIN_W-1:0]  mask_evt_pin,
    output logic              mask_evt_masked,
    output logic              svc_req_valid,
    output logic [PIN_W-1:0]  svc_req_pin
);

    localparam logic [DATA_W-1:0] VERSION_WORD =
        {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE};

    logic [SEL_W-1:0]   sel_q;
    logic [ID_W-1:0]    id_q;
    logic [7:0]         ofs;
    logic               wr_ok;
    logic               sel_wr;
    logic               win_wr;
    logic               id_wr;
    logic               tbl_wr;
    reg_kind_e          kind;
    logic [PIN_W-1:0]   idx;
    logic               upper;
    logic               idx_ok;
    logic [ENTRY_W-1:0] rd_entry;
    logic [ENTRY_W-1:0] wr_old;
    logic [ENTRY_W-1:0] wr_new;
    logic [DATA_W-1:0]  win_word;

    redir_sel_decode #(.NPINS(NPINS)) u_dec (
        .sel    (sel_q),
        .kind   (kind),
        .idx    (idx),
        .upper  (upper),
        .idx_ok (idx_ok)
    );

    // Qualify bus writes by offset and width.
    always_comb begin
        ofs    = bus_addr[7:0];
        wr_ok  = bus_valid && bus_write && bus_wide;
        sel_wr = wr_ok && (ofs == OFS_SELECT);
        win_wr = wr_ok && (ofs == OFS_WINDOW);
        id_wr  = win_wr && (kind == RK_IDENT);
        tbl_wr = win_wr && (kind == RK_TABLE) && idx_ok;
    end

    redir_table #(.NPINS(NPINS)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_wr),
        .wr_upper  (upper),
        .wr_idx    (idx),
        .wr_data   (bus_wdata),
        .set_valid (rirr_set_valid),
        .set_pin   (rirr_set_pin),
        .rd_idx    (idx),
        .rd_entry  (rd_entry),
        .wr_old    (wr_old),
        .wr_new    (wr_new)
    );

    redir_events #(.NPINS(NPINS)) u_evt (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (tbl_wr),
        .wr_idx          (idx),
        .wr_old          (wr_old),
        .wr_new          (wr_new),
        .pending         (pin_pending),
        .mask_evt_valid  (mask_evt_valid),
        .mask_evt_pin    (mask_evt_pin),
        .mask_evt_masked (mask_evt_masked),
        .svc_req_valid   (svc_req_valid),
        .svc_req_pin     (svc_req_pin)
    );

    // Select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    // Identifier register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (id_wr) begin
            id_q <= bus_wdata[ID_LSB +: ID_W];
        end
    end

    // Word seen through the window for the current select.
    always_comb begin
        unique case (kind)
            RK_VERSION:        win_word = VERSION_WORD;
            RK_IDENT, RK_ARBIT: win_word = DATA_W'(id_q) << ID_LSB;
            RK_TABLE:          win_word = !idx_ok ? '0 :
                                          (upper ? rd_entry[ENTRY_W-1:DATA_W]
                                                 : rd_entry[DATA_W-1:0]);
            default:           win_word = '0;
        endcase
    end

    // Bus read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            if (ofs == OFS_SELECT) begin
                bus_rdata = DATA_W'(sel_q);
            end else if (ofs == OFS_WINDOW) begin
                bus_rdata = win_word;
            end
        end
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_wr) |-> $stable(sel_q)); // R9
    AST_NARROW_NO_ID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid && bus_write && !bus_wide) |-> $stable(id_q)); // R10
    AST_OOR_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(win_wr && (kind == RK_TABLE) && !idx_ok) |-> (!mask_evt_valid && !svc_req_valid)); // R5

endmodule

// File: tb/irq_redir_regs_test.sv
module irq_redir_regs_test;

    localparam int NP     = 24;
    localparam int PW     = 5;
    localparam int AW     = 12;
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NP - 1), 8'h00, 8'h11};

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0000_0001},   // select version
        '{1'b1, 12'h010, VER_WORD},        // R1 read
        '{1'b0, 12'h010, 32'hFFFF_FFFF},   // R1 write ignored
        '{1'b1, 12'h010, VER_WORD},        // R1
        '{1'b0, 12'h000, 32'h0000_0000},   // select identifier
        '{1'b0, 12'h010, 32'hA500_0000},   // R2 store 5
        '{1'b1, 12'h010, 32'h0500_0000},   // R2
        '{1'b0, 12'h000, 32'h0000_0002},   // select arbitration
        '{1'b1, 12'h010, 32'h0500_0000},   // R3 alias
        '{1'b0, 12'h010, 32'h0F00_0000},   // R3 write ignored
        '{1'b1, 12'h010, 32'h0500_0000},   // R3
        '{1'b0, 12'h000, 32'h0000_0014},   // entry 2 low
        '{1'b0, 12'h010, 32'h0000_0031},   // R4
        '{1'b1, 12'h010, 32'h0000_0031},   // R4
        '{1'b0, 12'h000, 32'h0000_0015},   // entry 2 high
        '{1'b0, 12'h010, 32'hDEAD_BEEF},   // R4
        '{1'b1, 12'h010, 32'hDEAD_BEEF},   // R4
        '{1'b1, 12'h000, 32'h0000_0015},   // R9 select readback
        '{1'b1, 12'h020, 32'h0000_0000},   // R9 other offset
        '{1'b1, 12'h004, 32'h0000_0000}    // R9 other offset
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic          bus_wide = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_pending = '0;
    logic          rirr_set_valid = 1'b0;
    logic [PW-1:0] rirr_set_pin = '0;
    logic          mask_evt_valid;
    logic [PW-1:0] mask_evt_pin;
    logic          mask_evt_masked;
    logic          svc_req_valid;
    logic [PW-1:0] svc_req_pin;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_redir_regs #(.NPINS(NP), .ADDR_W(AW), .VER_CODE(8'h11)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_valid       (bus_valid),
        .bus_write       (bus_write),
        .bus_wide        (bus_wide),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .pin_pending     (pin_pending),
        .rirr_set_valid  (rirr_set_valid),
        .rirr_set_pin    (rirr_set_pin),
        .mask_evt_valid  (mask_evt_valid),
        .mask_evt_pin    (mask_evt_pin),
        .mask_evt_masked (mask_evt_masked),
        .svc_req_valid   (svc_req_valid),
        .svc_req_pin     (svc_req_pin)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // Write lasting one clock; returns at the negedge after the capturing edge.
    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic wide = 1'b1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wide = wide;
        bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wide = 1'b1;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
        #1;
    endtask

    task automatic rd_entry(input logic [7:0] s, output logic [31:0] d);
        bus_wr(12'h000, {24'h0, s});
        bus_rd(12'h010, d);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R11 outputs quiet during reset
        chk("R11 mask event in reset", 32'(mask_evt_valid), 32'h0);
        chk("R11 service in reset", 32'(svc_req_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        bus_rd(12'h000, r);
        chk("R11 select reset", r, 32'h0);
        bus_rd(12'h010, r);
        chk("R11 identifier reset", r, 32'h0);
        rd_entry(8'h10, r);
        chk("R11 entry0 low reset", r, 32'h0001_0000);
        rd_entry(8'h11, r);
        chk("R11 entry0 high reset", r, 32'h0);
        rd_entry(8'h3E, r);
        chk("R11 entry23 low reset", r, 32'h0001_0000);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_rd(VECS[i].addr, r);
                chk($sformatf("table row %0d", i), r, VECS[i].data);
            end else begin
                bus_wr(VECS[i].addr, VECS[i].data);
            end
        end

        // R4 even select still reaches the low half
        rd_entry(8'h14, r);
        chk("R4 entry2 low after high write", r, 32'h0000_0031);

        // R7 mask-change event
        bus_wr(12'h000, 32'h16);
        bus_wr(12'h010, 32'h0000_0040);
        chk("R7 unmask event valid", 32'(mask_evt_valid), 32'h1);
        chk("R7 unmask event pin", 32'(mask_evt_pin), 32'd3);
        chk("R7 unmask event value", 32'(mask_evt_masked), 32'h0);
        @(negedge clk);
        chk("R7 event lasts one cycle", 32'(mask_evt_valid), 32'h0);
        bus_wr(12'h010, 32'h0000_0040);
        chk("R7 no event without change", 32'(mask_evt_valid), 32'h0);
        bus_wr(12'h010, 32'h0001_0040);
        chk("R7 mask event valid", 32'(mask_evt_valid), 32'h1);
        chk("R7 mask event value", 32'(mask_evt_masked), 32'h1);

        // R8 service request
        pin_pending = NP'(1) << 5;
        bus_wr(12'h000, 32'h1A);
        bus_wr(12'h010, 32'h0000_8050);
        chk("R8 level pending request", 32'(svc_req_valid), 32'h1);
        chk("R8 request pin", 32'(svc_req_pin), 32'd5);
        bus_wr(12'h010, 32'h0000_0050);
        chk("R8 edge no request", 32'(svc_req_valid), 32'h0);
        pin_pending = '0;
        bus_wr(12'h010, 32'h0000_8050);
        chk("R8 not pending no request", 32'(svc_req_valid), 32'h0);

        // R6 remote IRR
        @(negedge clk);
        rirr_set_valid = 1'b1; rirr_set_pin = 5'd5;
        @(negedge clk);
        rirr_set_valid = 1'b0;
        bus_rd(12'h010, r);
        chk("R6 remote IRR set", r, 32'h0000_C050);
        bus_wr(12'h000, 32'h1B);
        bus_wr(12'h010, 32'h1200_0000);
        rd_entry(8'h1A, r);
        chk("R6 upper write keeps remote IRR", r, 32'h0000_C050);
        bus_wr(12'h010, 32'h0000_C050);
        bus_rd(12'h010, r);
        chk("R6 lower write clears remote IRR", r, 32'h0000_8050);

        // R5 out of range
        pin_pending = '1;
        bus_wr(12'h000, 32'h40);
        bus_wr(12'h010, 32'h0000_8000);
        chk("R5 no event out of range", 32'(mask_evt_valid), 32'h0);
        chk("R5 no request out of range", 32'(svc_req_valid), 32'h0);
        bus_rd(12'h010, r);
        chk("R5 read out of range", r, 32'h0);
        pin_pending = '0;
        rd_entry(8'h3E, r);
        chk("R5 last entry untouched", r, 32'h0001_0000);

        // R10 narrow writes
        bus_wr(12'h000, 32'h33, 1'b0);
        bus_rd(12'h000, r);
        chk("R10 narrow select write", r, 32'h3E);
        bus_wr(12'h010, 32'h0000_0000, 1'b0);
        chk("R10 narrow no event", 32'(mask_evt_valid), 32'h0);
        bus_rd(12'h010, r);
        chk("R10 narrow window write", r, 32'h0001_0000);

        // R9 only low address byte decoded
        bus_wr(12'h100, 32'h00);
        bus_wr(12'h110, 32'h0900_0000);
        bus_rd(12'h010, r);
        chk("R9 aliased offsets", r, 32'h0900_0000);
        bus_wr(12'h020, 32'h01);
        bus_rd(12'h000, r);
        chk("R9 other offset write ignored", r, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule